// File: doc/BRIEF.md
# Supervisory Reset Pulse Controller

This block generates the processor reset for a system from two digital inputs. The first is a synchronous supply-good flag, driven by an external comparator that watches the rail against its reset threshold. The second is an active-low pushbutton line. Reset is held active while the supply is judged low or the button is judged pressed. Once both conditions have cleared, reset stays active for a fixed stretch, so that the rail and the processor can settle.

Both inputs pass through low-run qualifiers, so brief dips on either one are ignored. The supply dip filter is a parameter. The pushbutton is first brought into the clock domain by two flip-flops and then debounced. The stretch counter reloads whenever a hold condition is present, so the stretch always counts from the moment the last condition clears. For the button, that moment is its release.

A parameter sets the pin polarity of the reset output. A separate, always active-high status output tells a companion watchdog that reset has ended. All timing is counted in clock cycles. The defaults assume a 100 MHz clock: a 200 ms stretch, a 1 µs button qualification and a 2 µs supply dip filter. Smaller values can be set for simulation.

Top module: `supervisor_reset_ctrl`

## Requirements
- R1: When `supply_ok` has been sampled low on SUPPLY_GLITCH_CYCLES consecutive clock edges, reset is active right after that edge. No stretch delay applies.
- R2: A low run on `supply_ok` shorter than SUPPLY_GLITCH_CYCLES samples has no effect: reset stays inactive if it was inactive.
- R3: After the last hold condition clears, reset stays active for exactly STRETCH_CYCLES more clock cycles and then goes inactive.
- R4: When `mr_n` is held low for at least BUTTON_QUAL_CYCLES samples, reset becomes active BUTTON_QUAL_CYCLES+2 clock edges after the first low sample. Two of those edges are the synchroniser.
- R5: A low pulse on `mr_n` shorter than BUTTON_QUAL_CYCLES samples is ignored.
- R6: During a long button press, reset stays active for the whole press. The stretch of STRETCH_CYCLES starts only when the button is released.
- R7: A new supply dip or button press during the stretch reloads the counter to its full value. The stretch then counts again from the end of that new condition.
- R8: With POLARITY = POL_ACTIVE_LOW, `sys_reset` is 0 while reset is active. With POL_ACTIVE_HIGH, it is 1 while reset is active.
- R9: `reset_inactive` is 1 only when the stretch has fully expired and no hold condition is present. Otherwise it is 0.
- R10: While `rst` is high, reset is active and the counter is held at its full value. After `rst` falls, reset stays active for STRETCH_CYCLES further cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Logic clock |
| rst | input | 1 | Synchronous active-high reset of the controller logic |
| supply_ok | input | 1 | Synchronous flag, 1 when the supply is above the reset threshold |
| mr_n | input | 1 | Asynchronous active-low pushbutton |
| sys_reset | output | 1 | Processor reset, polarity set by POLARITY |
| reset_inactive | output | 1 | 1 once reset has fully ended (watchdog enable) |

## Verification
All internal state is visible at the two outputs within one or two cycles:
- A qualifier that counts a run incorrectly shows up as reset rising one or more cycles early or late after a dip or a press. This is visible on the first cycle after the qualifying sample.
- A stretch counter that reloads or decrements incorrectly shows up as the wrong cycle for the fall of reset after release. This is seen at the end of the stretch.
- A missing reload during the stretch shows up as reset ending too early after a second event.

The reference model predicts both outputs on every cycle, so the first wrong cycle is reported.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic {
        POL_ACTIVE_LOW  = 1'b0,
        POL_ACTIVE_HIGH = 1'b1
    } rst_pol_e;

    typedef struct packed {
        logic supply_fault;
        logic button;
    } hold_src_t;

    function automatic int cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    function automatic logic pin_level(input logic active, input rst_pol_e pol);
        return (pol == POL_ACTIVE_HIGH) ? active : !active;
    endfunction

endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic stage1_q;
    logic stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= IDLE_LEVEL;
            stage2_q <= IDLE_LEVEL;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/sup_low_qualifier.sv
module sup_low_qualifier #(
    parameter int unsigned RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic qualified
);
    localparam int W = sup_pkg::cnt_bits(RUN_LEN);
    localparam logic [W-1:0] RUN_MAX = W'(RUN_LEN);

    logic [W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || level_in) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign qualified = (run_q == RUN_MAX);

    // R2 / R5: a high sample always cancels the qualified state
    assert_high_clears_R2: assert property (@(posedge clk) disable iff (rst)
        level_in |=> !qualified);

    // R1 / R4: qualification can only begin after a low sample
    assert_rise_needs_low_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(qualified) |-> !$past(level_in));
endmodule

// File: rtl/sup_stretch_timer.sv
module sup_stretch_timer #(
    parameter int unsigned HOLD_CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic active
);
    localparam int W = sup_pkg::cnt_bits(HOLD_CYCLES);
    localparam logic [W-1:0] CNT_FULL = W'(HOLD_CYCLES);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt_q <= CNT_FULL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = hold | (cnt_q != '0);

    // R3: with no hold, the stretch counts down one per cycle
    assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
        (!hold && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R6 / R7: when the hold ends, the counter stands at its full value
    assert_full_at_release_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |-> (cnt_q == CNT_FULL));
endmodule

// File: rtl/supervisor_reset_ctrl.sv
module supervisor_reset_ctrl #(
    parameter sup_pkg::rst_pol_e POLARITY         = sup_pkg::POL_ACTIVE_LOW,
    parameter int unsigned       STRETCH_CYCLES       = 20_000_000,
    parameter int unsigned       BUTTON_QUAL_CYCLES   = 100,
    parameter int unsigned       SUPPLY_GLITCH_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic mr_n,
    output logic sys_reset,
    output logic reset_inactive
);
    sup_pkg::hold_src_t causes;
    logic btn_sync;
    logic hold;
    logic rst_active;

    sup_sync2 #(.IDLE_LEVEL(1'b1)) u_btn_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (mr_n),
        .sync_out (btn_sync)
    );

    sup_low_qualifier #(.RUN_LEN(BUTTON_QUAL_CYCLES)) u_btn_qual (
        .clk       (clk),
        .rst       (rst),
        .level_in  (btn_sync),
        .qualified (causes.button)
    );

    sup_low_qualifier #(.RUN_LEN(SUPPLY_GLITCH_CYCLES)) u_sup_qual (
        .clk       (clk),
        .rst       (rst),
        .level_in  (supply_ok),
        .qualified (causes.supply_fault)
    );

    assign hold = |causes;

    sup_stretch_timer #(.HOLD_CYCLES(STRETCH_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .hold   (hold),
        .active (rst_active)
    );

    assign sys_reset      = sup_pkg::pin_level(rst_active, POLARITY);
    assign reset_inactive = !rst_active;

    // R1: a qualified supply fault is never reported as reset-inactive
    assert_fault_forces_R1: assert property (@(posedge clk) disable iff (rst)
        causes.supply_fault |-> !reset_inactive);
endmodule

// File: tb/supervisor_reset_ctrl_test.sv
module supervisor_reset_ctrl_test;
    localparam int TO = 40;
    localparam int DB = 4;
    localparam int GL = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b1;
    logic mr_n = 1'b1;
    logic rst_lo, inact_lo, rst_hi, inact_hi;

    always #5 clk = ~clk;

    supervisor_reset_ctrl #(
        .POLARITY(sup_pkg::POL_ACTIVE_LOW), .STRETCH_CYCLES(TO),
        .BUTTON_QUAL_CYCLES(DB), .SUPPLY_GLITCH_CYCLES(GL)
    ) uut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .mr_n(mr_n),
        .sys_reset(rst_lo), .reset_inactive(inact_lo)
    );

    supervisor_reset_ctrl #(
        .POLARITY(sup_pkg::POL_ACTIVE_HIGH), .STRETCH_CYCLES(TO),
        .BUTTON_QUAL_CYCLES(DB), .SUPPLY_GLITCH_CYCLES(GL)
    ) uut_hi (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .mr_n(mr_n),
        .sys_reset(rst_hi), .reset_inactive(inact_hi)
    );

    int tests = 0;
    int fails = 0;
    string cur_req = "R10";
    logic sup_hist[$];
    logic mr_hist[$];
    int since = 1;
    logic exp_active = 1'b1;
    logic started = 1'b0;
    logic done = 1'b0;
    int cycles = 0;

    // Behavioural reference: keep recent input samples, derive hold, time from last hold
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            sup_hist.delete();
            mr_hist.delete();
            for (int i = 0; i < GL; i++) sup_hist.push_front(1'b1);
            for (int i = 0; i < DB + 2; i++) mr_hist.push_front(1'b1);
            since = 1;
            exp_active = 1'b1;
        end else begin
            logic fault, pressed;
            sup_hist.push_front(supply_ok);
            void'(sup_hist.pop_back());
            mr_hist.push_front(mr_n);
            void'(mr_hist.pop_back());
            fault = 1'b1;
            for (int i = 0; i < GL; i++) if (sup_hist[i]) fault = 1'b0;
            pressed = 1'b1;
            for (int i = 2; i < DB + 2; i++) if (mr_hist[i]) pressed = 1'b0;
            if (fault || pressed) begin
                since = 0;
                exp_active = 1'b1;
            end else begin
                if (since < 1000000) since++;
                exp_active = (since <= TO);
            end
        end
        started = 1'b1;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            tests++;
            if (rst_lo !== !exp_active || rst_hi !== exp_active ||
                inact_lo !== !exp_active || inact_hi !== !exp_active) begin
                fails++;
                $display("FAIL %s cycle %0d: lo=%b hi=%b inact=%b/%b expected active=%b (R8 R9 polarity/status)",
                         cur_req, cycles, rst_lo, rst_hi, inact_lo, inact_hi, exp_active);
            end
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic supply_dip(input int n);
        supply_ok = 1'b0;
        wait_cycles(n);
        supply_ok = 1'b1;
    endtask

    task automatic press(input int n);
        mr_n = 1'b0;
        wait_cycles(n);
        mr_n = 1'b1;
    endtask

    task automatic point_check(input string req, input logic exp);
        tests++;
        if (inact_lo !== !exp || rst_hi !== exp) begin
            fails++;
            $display("FAIL %s directed: inact=%b hi=%b expected active=%b", req, inact_lo, rst_hi, exp);
        end
    endtask

    initial begin
        wait_cycles(3);
        point_check("R10", 1'b1);        // R10: active during rst
        rst = 1'b0;
        cur_req = "R10";
        wait_cycles(TO - 2);
        point_check("R10", 1'b1);        // still within stretch
        wait_cycles(10);
        point_check("R9", 1'b0);         // R9: inactive after expiry
        cur_req = "R2";
        supply_dip(GL - 1);
        wait_cycles(3);
        point_check("R2", 1'b0);         // R2: short dip ignored
        wait_cycles(10);
        cur_req = "R1";
        supply_dip(GL + 4);
        point_check("R1", 1'b1);         // R1: reset during long dip
        cur_req = "R3";
        wait_cycles(TO + 10);
        point_check("R3", 1'b0);         // R3: stretch ended
        cur_req = "R5";
        press(DB - 1);
        wait_cycles(6);
        point_check("R5", 1'b0);         // R5: short press ignored
        wait_cycles(10);
        cur_req = "R4";
        press(DB);
        wait_cycles(3);
        point_check("R4", 1'b1);         // R4: minimum press accepted
        wait_cycles(TO + 10);
        cur_req = "R6";
        press(30);
        point_check("R6", 1'b1);
        wait_cycles(TO);
        point_check("R6", 1'b1);         // R6: stretch counts from release
        wait_cycles(10);
        point_check("R6", 1'b0);
        cur_req = "R7";
        supply_dip(GL + 2);
        wait_cycles(20);
        press(10);
        wait_cycles(TO);
        point_check("R7", 1'b1);         // R7: reload extended the stretch
        wait_cycles(10);
        point_check("R7", 1'b0);
        cur_req = "R8";
        mr_n = 1'b0;
        supply_dip(12);
        mr_n = 1'b1;
        wait_cycles(TO + 10);
        cur_req = "R10";
        rst = 1'b1;
        wait_cycles(2);
        rst = 1'b0;
        wait_cycles(TO + 5);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait_cycles(100000);
        if (!done) begin
            done = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule